// File: doc/BRIEF.md
# Power-up Memory Pattern Tester

This engine checks a word-addressed synchronous memory before the rest of the system is allowed to use it. A start request launches a full sweep. The engine makes three passes over every word of the configured range. Each pass first writes one pattern to every word and then reads every word back and compares it. The first two patterns are complementary alternating-bit words. The third writes each word's own address, which catches address lines that are stuck or shorted and make words alias. Any word that reads back wrong marks the block that contains it as suspect. A block is one 16K-byte region by default, and its size is set as a parameter in words.

At the end the engine pulses `done_o` for one cycle. It then presents a status code and the suspect bitmap. The status tells apart three cases: the memory is missing, because block 0 gives back one fixed value whatever was written; the memory is sound; or hard faults were found. `busy_o` stays high for the whole run, so that any traffic on the shared bus can be held off until the test ends. Software can later run a single-block retest. The retest sweeps only the chosen block and replaces that block's flag with the new result, so a block stays mapped out until a retest clears it.

Top module: `mem_pattern_tester`

## Requirements
- R1: Every run makes three passes over its range, in this order: all bytes 0x55, all bytes 0xAA, then each word's zero-extended word address. Each pass writes every word in ascending address order and then reads every word back in ascending order. Read data is expected on `mem_rdata_i` one cycle after the read request.
- R2: A read-back mismatch on any word sets bit k of `map_o`, where k is the word address divided by BLK_WORDS.
- R3: A full run over memory that stores data correctly ends with status 1 and `map_o` all zero.
- R4: In a full run, status is 0 (absent) when every read of block 0 in all three passes returns the same value. Bit 0 of the bitmap is then always set, and a memory that always reads all ones sets every bit.
- R5: A full run that finds any mismatch without meeting the absent condition ends with status 2. This includes a stuck data bit and an address line that is ignored.
- R6: `done_o` is high for exactly one cycle. For a run over W words, it goes high after the 6*W+1-th rising edge that follows the edge which accepted the request. `busy_o` is high from the accepting edge until `done_o` falls.
- R7: `start_i` and `retest_i` have no effect while `busy_o` is high.
- R8: A full run, requested by `start_i`, clears all suspect flags before it tests.
- R9: A retest, requested by `retest_i` with `start_i` low, sweeps only block `retest_blk_i`. It replaces that block's flag with the new result and leaves the other flags unchanged. A retest never reports status 0. The suspect flags change only while a run is in progress.
- R10: `mem_req_o` is low whenever `busy_o` is low.
- R11: After reset, `busy_o`, `done_o`, `mem_req_o` and `map_o` are zero and status reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request a full sweep (sampled while idle) |
| retest_i | input | 1 | Request a single-block retest (sampled while idle) |
| retest_blk_i | input | BLK_W | Block to retest |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle completion pulse |
| status_o | output | 2 | 0 absent, 1 good, 2 faults |
| map_o | output | NUM_BLKS | Suspect flag per block |
| mem_req_o | output | 1 | Memory access strobe |
| mem_we_o | output | 1 | Write when high, read when low |
| mem_addr_o | output | ADDR_W | Word address |
| mem_wdata_o | output | DATA_W | Write data |
| mem_rdata_i | input | DATA_W | Read data, one cycle after a read |

## Verification
The properties assume that the memory answers every read with data in the following cycle. They also assume that `retest_blk_i` matters only in the cycle a request is accepted, so its value at other times is not checked. The bench's memory model has a fixed one-cycle registered read, which keeps it within the first assumption. The bench drives requests and block selects only at negative edges. It injects faults by changing the model between runs and never during one, so each expected bitmap follows directly from the fault that was placed.

// File: rtl/mtst_pkg.sv
package mtst_pkg;
  typedef enum logic [1:0] {ST_ABSENT = 2'd0, ST_GOOD = 2'd1, ST_FAULT = 2'd2} status_e;
  typedef enum logic [2:0] {S_IDLE, S_WRITE, S_READ, S_DRAIN, S_DONE} state_e;
  typedef enum logic [1:0] {P_LO = 2'd0, P_HI = 2'd1, P_ADR = 2'd2} pass_e;
endpackage

// File: rtl/mtst_pattern.sv
module mtst_pattern
  import mtst_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 16
) (
  input  pass_e              pass_i,
  input  logic [ADDR_W-1:0]  addr_i,
  output logic [DATA_W-1:0]  pat_o
);
  logic [DATA_W-1:0] alt_pat;

  // 0x55 per byte: even bits set
  for (genvar b = 0; b < DATA_W; b++) begin : g_alt
    assign alt_pat[b] = (b % 2 == 0);
  end

  always_comb begin
    unique case (pass_i)
      P_LO:    pat_o = alt_pat;
      P_HI:    pat_o = ~alt_pat;
      P_ADR:   pat_o = DATA_W'(addr_i);
      default: pat_o = '0;
    endcase
  end
endmodule

// File: rtl/mtst_addr_seq.sv
module mtst_addr_seq #(
  parameter int ADDR_W = 16,
  parameter int BLK_W  = 4,
  localparam int OFS_W = ADDR_W - BLK_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              full_i,
  input  logic [BLK_W-1:0]  blk_i,
  input  logic              step_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              last_o
);
  logic             full_q;
  logic [BLK_W-1:0] blk_q;
  logic [ADDR_W-1:0] lo, hi;

  assign lo     = full_q ? '0 : {blk_q, {OFS_W{1'b0}}};
  assign hi     = full_q ? '1 : {blk_q, {OFS_W{1'b1}}};
  assign last_o = (addr_o == hi);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      blk_q  <= '0;
      addr_o <= '0;
    end else if (load_i) begin
      full_q <= full_i;
      blk_q  <= blk_i;
      addr_o <= full_i ? '0 : {blk_i, {OFS_W{1'b0}}};
    end else if (step_i) begin
      addr_o <= last_o ? lo : addr_o + 1'b1;
    end
  end
endmodule

// File: rtl/mtst_fault_map.sv
module mtst_fault_map #(
  parameter int NUM_BLKS = 16,
  localparam int BLK_W = $clog2(NUM_BLKS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                clr_all_i,
  input  logic                clr_one_i,
  input  logic [BLK_W-1:0]    clr_blk_i,
  input  logic                set_i,
  input  logic [BLK_W-1:0]    set_blk_i,
  output logic [NUM_BLKS-1:0] map_o
);
  for (genvar k = 0; k < NUM_BLKS; k++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                        map_o[k] <= 1'b0;
      else if (clr_all_i)                                 map_o[k] <= 1'b0;
      else if (clr_one_i && clr_blk_i == BLK_W'(k))       map_o[k] <= 1'b0;
      else if (set_i && set_blk_i == BLK_W'(k))           map_o[k] <= 1'b1;
    end
  end
endmodule

// File: rtl/mem_pattern_tester.sv
module mem_pattern_tester
  import mtst_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int BLK_WORDS = 4096,
  parameter int NUM_BLKS  = 16,
  localparam int OFS_W  = $clog2(BLK_WORDS),
  localparam int BLK_W  = $clog2(NUM_BLKS),
  localparam int ADDR_W = OFS_W + BLK_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic                retest_i,
  input  logic [BLK_W-1:0]    retest_blk_i,
  output logic                busy_o,
  output logic                done_o,
  output logic [1:0]          status_o,
  output logic [NUM_BLKS-1:0] map_o,
  output logic                mem_req_o,
  output logic                mem_we_o,
  output logic [ADDR_W-1:0]   mem_addr_o,
  output logic [DATA_W-1:0]   mem_wdata_o,
  input  logic [DATA_W-1:0]   mem_rdata_i
);
  state_e            state;
  pass_e             pass;
  logic              full_q;
  logic              accept, last, mismatch, in_blk0;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] pat;
  logic              cmp_vld;
  logic [ADDR_W-1:0] cmp_addr;
  logic [DATA_W-1:0] cmp_exp;
  logic              float_ok, have_first;
  logic [DATA_W-1:0] first_val;

  assign accept = (state == S_IDLE) && (start_i || retest_i);

  mtst_addr_seq #(.ADDR_W(ADDR_W), .BLK_W(BLK_W)) u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (accept),
    .full_i (start_i),
    .blk_i  (retest_blk_i),
    .step_i (mem_req_o),
    .addr_o (addr),
    .last_o (last)
  );

  mtst_pattern #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_pat (
    .pass_i (pass),
    .addr_i (addr),
    .pat_o  (pat)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state  <= S_IDLE;
      pass   <= P_LO;
      full_q <= 1'b0;
    end else begin
      unique case (state)
        S_IDLE: if (accept) begin
          state  <= S_WRITE;
          pass   <= P_LO;
          full_q <= start_i;
        end
        S_WRITE: if (last) state <= S_READ;
        S_READ: if (last) begin
          if (pass == P_ADR) state <= S_DRAIN;
          else begin
            pass  <= pass_e'(pass + 2'd1);
            state <= S_WRITE;
          end
        end
        S_DRAIN: state <= S_DONE;
        S_DONE:  state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  // compare stage, aligned with the one-cycle read latency
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmp_vld  <= 1'b0;
      cmp_addr <= '0;
      cmp_exp  <= '0;
    end else begin
      cmp_vld  <= (state == S_READ);
      cmp_addr <= addr;
      cmp_exp  <= pat;
    end
  end

  assign mismatch = cmp_vld && (mem_rdata_i != cmp_exp);
  assign in_blk0  = (cmp_addr[ADDR_W-1:OFS_W] == '0);

  // absent memory: block 0 returns one fixed value throughout
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      float_ok   <= 1'b0;
      have_first <= 1'b0;
      first_val  <= '0;
    end else if (accept) begin
      float_ok   <= 1'b1;
      have_first <= 1'b0;
    end else if (cmp_vld && full_q && in_blk0) begin
      if (!have_first) begin
        first_val  <= mem_rdata_i;
        have_first <= 1'b1;
      end else if (mem_rdata_i != first_val) begin
        float_ok <= 1'b0;
      end
    end
  end

  mtst_fault_map #(.NUM_BLKS(NUM_BLKS)) u_map (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_all_i (accept && start_i),
    .clr_one_i (accept && !start_i),
    .clr_blk_i (retest_blk_i),
    .set_i     (mismatch),
    .set_blk_i (cmp_addr[ADDR_W-1:OFS_W]),
    .map_o     (map_o)
  );

  always_comb begin
    if (full_q && float_ok) status_o = ST_ABSENT;
    else if (|map_o)        status_o = ST_FAULT;
    else                    status_o = ST_GOOD;
  end

  assign busy_o      = (state != S_IDLE);
  assign done_o      = (state == S_DONE);
  assign mem_req_o   = (state == S_WRITE) || (state == S_READ);
  assign mem_we_o    = (state == S_WRITE);
  assign mem_addr_o  = addr;
  assign mem_wdata_o = pat;
endmodule

// File: rtl/mtst_checker.sv
module mtst_checker #(
  parameter int NUM_BLKS = 16
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                start_i,
  input logic                retest_i,
  input logic                busy_i,
  input logic                done_i,
  input logic [1:0]          status_i,
  input logic [NUM_BLKS-1:0] map_i,
  input logic                mem_req_i
);
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> !done_i); // R6
  AST_IDLE_NO_ACCESS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> !mem_req_i); // R10
  AST_GOOD_CLEAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && status_i == 2'd1) |-> (map_i == '0)); // R3
  AST_FAULT_MARKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && status_i == 2'd2) |-> (map_i != '0)); // R5
  AST_ABSENT_BLK0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && status_i == 2'd0) |-> map_i[0]); // R4
  AST_BUSY_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && !done_i) |=> busy_i); // R7
  AST_MAP_QUIET_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_i && !start_i && !retest_i) |=> $stable(map_i)); // R9
endmodule

bind mem_pattern_tester mtst_checker #(.NUM_BLKS(NUM_BLKS)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .retest_i  (retest_i),
  .busy_i    (busy_o),
  .done_i    (done_o),
  .status_i  (status_o),
  .map_i     (map_o),
  .mem_req_i (mem_req_o)
);

// File: tb/sim_mem_pattern_tester.sv
module sim_mem_pattern_tester;
  localparam int DW = 16;
  localparam int BW = 8;
  localparam int NB = 4;
  localparam int AW = 5;
  localparam int NW = NB * BW;

  // mode: 0 sound, 1 stuck-at-1 bits on one word, 2 absent (reads all ones), 3 address bit 4 ignored
  typedef struct packed {
    logic [1:0]    mode;
    logic [AW-1:0] fa;
    logic [DW-1:0] mask;
    logic [1:0]    st;
    logic [NB-1:0] map;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{2'd0, 5'd0,  16'h0000, 2'd1, 4'b0000},  // R3
    '{2'd1, 5'd3,  16'h0001, 2'd2, 4'b0001},  // R2 R5
    '{2'd1, 5'd20, 16'h8000, 2'd2, 4'b0100},  // R2
    '{2'd2, 5'd0,  16'h0000, 2'd0, 4'b1111},  // R4
    '{2'd3, 5'd0,  16'h0000, 2'd2, 4'b0011},  // R1 R5
    '{2'd1, 5'd31, 16'h0002, 2'd2, 4'b1000}   // R1 R2
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, retest = 1'b0;
  logic [1:0] rblk = '0;
  logic busy, done, mreq, mwe;
  logic [1:0] status;
  logic [NB-1:0] map;
  logic [AW-1:0] maddr;
  logic [DW-1:0] mwdata;
  logic [DW-1:0] mrdata = '0;
  logic [DW-1:0] mem [NW];

  logic [1:0]    f_mode = '0;
  logic [AW-1:0] f_addr = '0;
  logic [DW-1:0] f_mask = '0;

  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  mem_pattern_tester #(.DATA_W(DW), .BLK_WORDS(BW), .NUM_BLKS(NB)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .retest_i(retest),
    .retest_blk_i(rblk), .busy_o(busy), .done_o(done), .status_o(status),
    .map_o(map), .mem_req_o(mreq), .mem_we_o(mwe), .mem_addr_o(maddr),
    .mem_wdata_o(mwdata), .mem_rdata_i(mrdata)
  );

  function automatic logic [AW-1:0] eff(input logic [AW-1:0] a);
    return (f_mode == 2'd3) ? {1'b0, a[AW-2:0]} : a;
  endfunction

  always @(posedge clk) begin
    if (mreq && mwe) mem[eff(maddr)] <= mwdata;
    if (mreq && !mwe) begin
      if (f_mode == 2'd2)                         mrdata <= '1;
      else if (f_mode == 2'd1 && maddr == f_addr) mrdata <= mem[maddr] | f_mask;
      else                                        mrdata <= mem[eff(maddr)];
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // poke > 0: drive start and retest for one cycle at that count while busy
  task automatic run(input logic full, input logic [1:0] blk, input int poke, output int cyc);
    @(negedge clk);
    start = full; retest = !full; rblk = blk;
    @(negedge clk);
    start = 1'b0; retest = 1'b0; rblk = ~blk;
    cyc = 1;
    while (!done && cyc < 2000) begin
      @(negedge clk);
      cyc++;
      if (cyc == poke) begin start = 1'b1; retest = 1'b1; end
      if (cyc == poke + 1) begin start = 1'b0; retest = 1'b0; end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int cyc;
    repeat (3) @(negedge clk);
    chk("R11 busy", busy, 0);
    chk("R11 done", done, 0);
    chk("R11 req", mreq, 0);
    chk("R11 map", map, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 status", status, 1);
    chk("R10 idle req", mreq, 0);

    for (int i = 0; i < 6; i++) begin
      f_mode = VECS[i].mode; f_addr = VECS[i].fa; f_mask = VECS[i].mask;
      run(1'b1, 2'd0, 0, cyc);
      chk("R6 full latency", cyc, 6 * NW + 2);
      chk("R3 R4 R5 status", status, VECS[i].st);
      chk("R2 R8 map", map, VECS[i].map);
      @(negedge clk);
      chk("R6 done one cycle", done, 0);
      chk("R6 busy low", busy, 0);
    end

    // start and retest ignored mid-run
    f_mode = 2'd1; f_addr = 5'd3; f_mask = 16'h0001;
    run(1'b1, 2'd0, 60, cyc);
    chk("R7 latency unchanged", cyc, 6 * NW + 2);
    chk("R7 map", map, 4'b0001);
    @(negedge clk);

    // retests
    f_addr = 5'd20; f_mask = 16'h8000;
    run(1'b1, 2'd0, 0, cyc);
    chk("R8 map", map, 4'b0100);
    @(negedge clk);
    f_addr = 5'd3; f_mask = 16'h0001;
    run(1'b0, 2'd0, 0, cyc);
    chk("R9 retest latency", cyc, 6 * BW + 2);
    chk("R9 other flag kept", map, 4'b0101);
    chk("R9 status", status, 2);
    @(negedge clk);
    f_mode = 2'd0;
    run(1'b0, 2'd2, 0, cyc);
    chk("R9 clear blk2", map, 4'b0001);
    @(negedge clk);
    run(1'b0, 2'd0, 0, cyc);
    chk("R9 clear blk0", map, 4'b0000);
    chk("R9 status good", status, 1);
    @(negedge clk);
    f_mode = 2'd2;
    run(1'b0, 2'd0, 0, cyc);
    chk("R9 never absent", status, 2);
    repeat (3) @(negedge clk);
    chk("R9 map quiet idle", map, 4'b0001);
    chk("R10 idle req", mreq, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule